// File: doc/BRIEF.md
# Floating-Point Compare Unit

This block compares two IEEE-754 double-precision values, the value at the top of an eight-entry register stack and a source value, and reports the relation as a condition code. Along the way it classifies both operands. A NaN, or a stack register that is tagged empty, makes the result unordered and can raise an invalid-operand flag. A subnormal operand raises a denormal flag, and an empty register also raises a stack-underflow flag. The block keeps the stack's top pointer and its per-register full tags. A compare may also pop the stack once or twice.

A request is a one-cycle `start` strobe together with a 2-bit operation select: 0 plain compare, 1 compare then pop once, 2 compare then pop twice, 3 quiet compare. The two operand values come from the register file. The block checks the tags of the registers they occupy. These are ST(0) at the top pointer, and ST(i) at the top pointer plus i modulo 8. The source is ST(1) unless `use_idx` selects `src_idx`. The stack state can be loaded through `ld_en`, which lets the surrounding register file set it up.

The controller has two states. In S_IDLE the block waits. A `start` seen in S_IDLE is accepted: the result, flags and pops are written on that edge, and the transition goes to S_DONE. S_DONE drives `done` for one cycle and always returns to S_IDLE. A `start` seen in S_DONE is dropped.

Top module: `fcmp_unit`

## Requirements
- R1: After a compare, `cond` bits {3,2,0} (C3,C2,C0) read 000 if top > source, 001 if top < source and 100 if they are equal. Infinities order normally.
- R2: Negative zero and positive zero compare equal (`cond` = 4'b1000).
- R3: In operation 0, 1 or 2, a NaN operand (exponent all ones, fraction non-zero) sets `flag_ia`. With `inv_mask`=1, `cond` becomes 4'b1101.
- R4: When the invalid condition arises with `inv_mask`=0, C3, C2 and C0 keep their previous values.
- R5: C1 (`cond[1]`) is 0 after every compare.
- R6: A quiet compare (operation 3) does not set `flag_ia` for a quiet NaN (fraction MSB 1), and gives `cond`=4'b1101 regardless of the mask. A signaling NaN (fraction MSB 0) still sets `flag_ia`.
- R7: Operation 1 clears the tag at the top pointer and adds 1 to the pointer. Operation 2 does this twice. The pointer wraps modulo 8.
- R8: If the tag of ST(0) or of the source is 0 (empty), `flag_is` and `flag_ia` are set. `cond` then follows R3/R4, and the requested pops still happen.
- R9: A subnormal operand (exponent 0, fraction non-zero) sets `flag_de`, and the relation is still reported per R1.
- R10: With `use_idx`=0 the source register is ST(1). With `use_idx`=1 it is ST(`src_idx`).
- R11: `done` is high for exactly the cycle after an accepted `start`. A `start` while `done` is high is ignored.
- R12: `flag_ia`, `flag_is` and `flag_de` are sticky. `clr_flags` clears them on the next edge, and flags raised on that same edge are then ORed in.
- R13: After reset `cond`=0, all flags are 0, `done`=0, `top_ptr`=0 and `tags`=0. When no `start` is accepted, `ld_en` loads `top_ptr` and `tags`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request strobe |
| op | input | 2 | 0 compare, 1 compare+pop, 2 compare+pop twice, 3 quiet compare |
| use_idx | input | 1 | 1: source is ST(src_idx); 0: ST(1) |
| src_idx | input | 3 | Source stack offset |
| top_val | input | 64 | ST(0) value |
| src_val | input | 64 | Source value |
| inv_mask | input | 1 | Invalid-operation mask |
| clr_flags | input | 1 | Clear the sticky flags |
| ld_en | input | 1 | Load the stack state |
| ld_top | input | 3 | Top pointer to load |
| ld_tags | input | 8 | Tags to load (1 = full) |
| done | output | 1 | Result valid pulse |
| cond | output | 4 | {C3,C2,C1,C0} |
| flag_ia | output | 1 | Sticky invalid-operand flag |
| flag_is | output | 1 | Sticky stack-underflow flag |
| flag_de | output | 1 | Sticky denormal flag |
| top_ptr | output | 3 | Stack top pointer |
| tags | output | 8 | Per-register full tags |

## Verification
Some properties are checked by the assertions on every cycle:
- `cond` only ever holds one of the four legal codes, and C1 is clear whenever `done` is high.
- `done` follows an accepted start and lasts one cycle.
- The underflow flag never stands without the invalid flag, and the flags hold while no clear is requested.
- Each pop advances the pointer by the requested amount and empties the old top.

Other behaviours depend on the operand values and only the bench scenarios can show them:
- the ordering of signed zeros, subnormals and NaN kinds;
- whether the quiet variant spares a quiet NaN;
- whether an unmasked invalid leaves C3, C2 and C0 untouched;
- whether the default source is ST(1).

The bench checks these against a reference that orders the values as real numbers.

// File: rtl/fcmp_pkg.sv
package fcmp_pkg;

    typedef enum logic [1:0] {
        OP_CMP      = 2'd0,
        OP_CMP_POP  = 2'd1,
        OP_CMP_POP2 = 2'd2,
        OP_UCMP     = 2'd3
    } cmp_op_e;

    typedef enum logic [1:0] {
        REL_GT = 2'd0,
        REL_LT = 2'd1,
        REL_EQ = 2'd2
    } rel_e;

    typedef enum logic {
        S_IDLE = 1'b0,
        S_DONE = 1'b1
    } state_e;

    typedef struct packed {
        logic is_nan;
        logic is_snan;
        logic is_denorm;
    } fp_class_t;

    // {C3,C2,C1,C0}
    localparam logic [3:0] CC_GT = 4'b0000;
    localparam logic [3:0] CC_LT = 4'b0001;
    localparam logic [3:0] CC_EQ = 4'b1000;
    localparam logic [3:0] CC_UN = 4'b1101;

endpackage

// File: rtl/fcmp_classify.sv
module fcmp_classify
    import fcmp_pkg::*;
#(
    parameter int EXP_W  = 11,
    parameter int FRAC_W = 52,
    localparam int FP_W  = EXP_W + FRAC_W + 1
) (
    input  logic [FP_W-1:0] val,
    output fp_class_t       cls
);
    logic [EXP_W-1:0]  exp_f;
    logic [FRAC_W-1:0] frac_f;
    logic              exp_max;
    logic              exp_zero;
    logic              frac_nz;

    always_comb begin
        exp_f         = val[FP_W-2 -: EXP_W];
        frac_f        = val[FRAC_W-1:0];
        exp_max       = &exp_f;
        exp_zero      = ~|exp_f;
        frac_nz       = |frac_f;
        cls.is_nan    = exp_max && frac_nz;
        // A quiet NaN has the fraction MSB set.
        cls.is_snan   = exp_max && frac_nz && !frac_f[FRAC_W-1];
        cls.is_denorm = exp_zero && frac_nz;
    end
endmodule

// File: rtl/fcmp_magcmp.sv
module fcmp_magcmp
    import fcmp_pkg::*;
#(
    parameter int FP_W = 64
) (
    input  logic [FP_W-1:0] a,
    input  logic [FP_W-1:0] b,
    output rel_e            rel
);
    logic [FP_W-2:0] mag_a;
    logic [FP_W-2:0] mag_b;
    logic            both_zero;

    always_comb begin
        mag_a     = a[FP_W-2:0];
        mag_b     = b[FP_W-2:0];
        both_zero = (mag_a == '0) && (mag_b == '0);
        if (both_zero || (a == b)) begin
            rel = REL_EQ;
        end else if (a[FP_W-1] != b[FP_W-1]) begin
            rel = a[FP_W-1] ? REL_LT : REL_GT;
        end else if (mag_a > mag_b) begin
            rel = a[FP_W-1] ? REL_LT : REL_GT;
        end else begin
            rel = a[FP_W-1] ? REL_GT : REL_LT;
        end
    end
endmodule

// File: rtl/fcmp_stack.sv
module fcmp_stack #(
    parameter int DEPTH  = 8,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld_en,
    input  logic [PTR_W-1:0] ld_top,
    input  logic [DEPTH-1:0] ld_tags,
    input  logic             pop_en,
    input  logic [1:0]       pop_cnt,
    input  logic [PTR_W-1:0] src_off,
    output logic [PTR_W-1:0] top_q,
    output logic [DEPTH-1:0] tags_q,
    output logic             top_full,
    output logic             src_full
);
    logic [PTR_W-1:0] second;
    logic [PTR_W-1:0] src_pos;
    logic [PTR_W-1:0] top_d;
    logic [DEPTH-1:0] tags_d;

    always_comb begin
        second   = PTR_W'(top_q + PTR_W'(1));
        src_pos  = PTR_W'(top_q + src_off);
        top_full = tags_q[top_q];
        src_full = tags_q[src_pos];
        if (pop_en)
            top_d = PTR_W'(top_q + PTR_W'(pop_cnt));
        else if (ld_en)
            top_d = ld_top;
        else
            top_d = top_q;
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_tag
        logic kill;
        always_comb begin
            kill = pop_en && (((pop_cnt != 2'd0) && (top_q == PTR_W'(g))) ||
                              ((pop_cnt == 2'd2) && (second == PTR_W'(g))));
            if (pop_en)
                tags_d[g] = tags_q[g] & ~kill;
            else if (ld_en)
                tags_d[g] = ld_tags[g];
            else
                tags_d[g] = tags_q[g];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            top_q  <= '0;
            tags_q <= '0;
        end else begin
            top_q  <= top_d;
            tags_q <= tags_d;
        end
    end

    // R7: each pop step advances the pointer by the requested count
    p_pop_advance_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pop_en |=> (top_q == PTR_W'($past(top_q) + PTR_W'($past(pop_cnt)))));

    // R7: a real pop leaves the old top register empty
    p_pop_empties_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_en && pop_cnt != 2'd0) |=> !tags_q[$past(top_q)]);
endmodule

// File: rtl/fcmp_unit.sv
module fcmp_unit
    import fcmp_pkg::*;
#(
    parameter int FP_W   = 64,
    parameter int EXP_W  = 11,
    parameter int DEPTH  = 8,
    localparam int FRAC_W = FP_W - EXP_W - 1,
    localparam int PTR_W  = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [1:0]       op,
    input  logic             use_idx,
    input  logic [PTR_W-1:0] src_idx,
    input  logic [FP_W-1:0]  top_val,
    input  logic [FP_W-1:0]  src_val,
    input  logic             inv_mask,
    input  logic             clr_flags,
    input  logic             ld_en,
    input  logic [PTR_W-1:0] ld_top,
    input  logic [DEPTH-1:0] ld_tags,
    output logic             done,
    output logic [3:0]       cond,
    output logic             flag_ia,
    output logic             flag_is,
    output logic             flag_de,
    output logic [PTR_W-1:0] top_ptr,
    output logic [DEPTH-1:0] tags
);
    state_e           state_q, state_d;
    cmp_op_e          op_e;
    logic             accepted;
    fp_class_t        cls_top, cls_src;
    rel_e             rel;
    logic             top_full, src_full;
    logic [PTR_W-1:0] src_off;
    logic [1:0]       pop_cnt;
    logic             underflow, any_nan, any_snan;
    logic             ia_new, de_new, unordered;
    logic [3:0]       cond_d;
    logic             ia_base, is_base, de_base;

    fcmp_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls_top (
        .val (top_val),
        .cls (cls_top)
    );

    fcmp_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls_src (
        .val (src_val),
        .cls (cls_src)
    );

    fcmp_magcmp #(.FP_W(FP_W)) u_mag (
        .a   (top_val),
        .b   (src_val),
        .rel (rel)
    );

    fcmp_stack #(.DEPTH(DEPTH)) u_stack (
        .clk      (clk),
        .rst_n    (rst_n),
        .ld_en    (ld_en && !accepted),
        .ld_top   (ld_top),
        .ld_tags  (ld_tags),
        .pop_en   (accepted),
        .pop_cnt  (pop_cnt),
        .src_off  (src_off),
        .top_q    (top_ptr),
        .tags_q   (tags),
        .top_full (top_full),
        .src_full (src_full)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        op_e     = cmp_op_e'(op);
        accepted = (state_q == S_IDLE) && start;
        unique case (state_q)
            S_IDLE:  state_d = start ? S_DONE : S_IDLE;
            S_DONE:  state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // Operand checks and result selection
    always_comb begin
        src_off   = use_idx ? src_idx : PTR_W'(1);
        underflow = !top_full || !src_full;
        any_nan   = cls_top.is_nan || cls_src.is_nan;
        any_snan  = cls_top.is_snan || cls_src.is_snan;
        unordered = underflow || any_nan;
        ia_new    = underflow || ((op_e == OP_UCMP) ? any_snan : any_nan);
        de_new    = cls_top.is_denorm || cls_src.is_denorm;
        unique case (op_e)
            OP_CMP_POP:  pop_cnt = 2'd1;
            OP_CMP_POP2: pop_cnt = 2'd2;
            default:     pop_cnt = 2'd0;
        endcase
        if (ia_new && !inv_mask) begin
            cond_d = {cond[3], cond[2], 1'b0, cond[0]};
        end else if (unordered) begin
            cond_d = CC_UN;
        end else begin
            unique case (rel)
                REL_GT:  cond_d = CC_GT;
                REL_LT:  cond_d = CC_LT;
                default: cond_d = CC_EQ;
            endcase
        end
        ia_base = flag_ia && !clr_flags;
        is_base = flag_is && !clr_flags;
        de_base = flag_de && !clr_flags;
    end

    // Result and flag registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cond    <= CC_GT;
            flag_ia <= 1'b0;
            flag_is <= 1'b0;
            flag_de <= 1'b0;
        end else if (accepted) begin
            cond    <= cond_d;
            flag_ia <= ia_base || ia_new;
            flag_is <= is_base || underflow;
            flag_de <= de_base || de_new;
        end else begin
            flag_ia <= ia_base;
            flag_is <= is_base;
            flag_de <= de_base;
        end
    end

    // Outputs derived from state
    always_comb begin
        done = (state_q == S_DONE);
    end

    // R11: an accepted start is answered on the next cycle
    p_done_follows_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == S_IDLE) && start) |=> done);

    // R11: done lasts a single cycle
    p_done_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R5: C1 is clear when a result is presented
    p_c1_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !cond[1]);

    // R1: only the four legal codes ever appear
    p_cond_legal_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (cond == CC_GT) || (cond == CC_LT) || (cond == CC_EQ) || (cond == CC_UN));

    // R8: underflow never stands without invalid
    p_is_has_ia_r8: assert property (@(posedge clk) disable iff (!rst_n)
        flag_is |-> flag_ia);

    // R12: flags persist while no clear is requested
    p_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_ia && !clr_flags) |=> flag_ia);
endmodule

// File: tb/fcmp_unit_bench.sv
`timescale 1ns/1ps
module fcmp_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  op = 2'd0;
    logic        use_idx = 1'b0;
    logic [2:0]  src_idx = 3'd0;
    logic [63:0] top_val = '0;
    logic [63:0] src_val = '0;
    logic        inv_mask = 1'b1;
    logic        clr_flags = 1'b0;
    logic        ld_en = 1'b0;
    logic [2:0]  ld_top = 3'd0;
    logic [7:0]  ld_tags = 8'd0;
    logic        done;
    logic [3:0]  cond;
    logic        flag_ia, flag_is, flag_de;
    logic [2:0]  top_ptr;
    logic [7:0]  tags;

    always #4 clk = ~clk;

    fcmp_unit u_fcmp_unit (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op), .use_idx(use_idx),
        .src_idx(src_idx), .top_val(top_val), .src_val(src_val),
        .inv_mask(inv_mask), .clr_flags(clr_flags), .ld_en(ld_en),
        .ld_top(ld_top), .ld_tags(ld_tags), .done(done), .cond(cond),
        .flag_ia(flag_ia), .flag_is(flag_is), .flag_de(flag_de),
        .top_ptr(top_ptr), .tags(tags)
    );

    // Reference model state
    bit [3:0] m_cond;
    bit       m_ia, m_is, m_de, m_done;
    bit [2:0] m_top;
    bit [7:0] m_tags;
    int       n_chk = 0;
    int       n_bad = 0;
    bit       chk_on = 1'b0;
    bit       finished = 1'b0;
    string    cur_req = "R13";

    function automatic bit is_nan(input logic [63:0] v);
        return (v[62:52] == 11'h7FF) && (v[51:0] != 0);
    endfunction
    function automatic bit is_snan(input logic [63:0] v);
        return is_nan(v) && !v[51];
    endfunction
    function automatic bit is_sub(input logic [63:0] v);
        return (v[62:52] == 0) && (v[51:0] != 0);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cond = 0; m_ia = 0; m_is = 0; m_de = 0; m_done = 0;
            m_top = 0; m_tags = 0;
        end else begin
            bit acc, uf, nan_any, inv, unord;
            bit [2:0] sp;
            real ra, rb;
            int npop;
            acc = start && !m_done;
            if (clr_flags) begin m_ia = 0; m_is = 0; m_de = 0; end
            if (acc) begin
                sp = m_top + (use_idx ? src_idx : 3'd1);
                uf = !m_tags[m_top] || !m_tags[sp];
                nan_any = is_nan(top_val) || is_nan(src_val);
                inv = uf || ((op == 2'd3) ? (is_snan(top_val) || is_snan(src_val)) : nan_any);
                unord = uf || nan_any;
                ra = $bitstoreal(top_val);
                rb = $bitstoreal(src_val);
                if (inv && !inv_mask) m_cond[1] = 1'b0;
                else if (unord)       m_cond = 4'b1101;
                else if (ra > rb)     m_cond = 4'b0000;
                else if (ra < rb)     m_cond = 4'b0001;
                else                  m_cond = 4'b1000;
                if (inv) m_ia = 1;
                if (uf) m_is = 1;
                if (is_sub(top_val) || is_sub(src_val)) m_de = 1;
                npop = (op == 2'd1) ? 1 : (op == 2'd2) ? 2 : 0;
                for (int k = 0; k < npop; k++) begin
                    m_tags[m_top] = 1'b0;
                    m_top = m_top + 3'd1;
                end
                m_done = 1;
            end else begin
                m_done = 0;
                if (ld_en) begin m_top = ld_top; m_tags = ld_tags; end
            end
        end
    end

    // Compare on every clock, away from the active edge
    always @(negedge clk) begin
        if (chk_on && !finished) begin
            n_chk++;
            if (done !== m_done || cond !== m_cond || flag_ia !== m_ia ||
                flag_is !== m_is || flag_de !== m_de || top_ptr !== m_top ||
                tags !== m_tags) begin
                n_bad++;
                $display("FAIL %s: got done=%b cond=%b ia=%b is=%b de=%b top=%0d tags=%b, exp done=%b cond=%b ia=%b is=%b de=%b top=%0d tags=%b",
                    cur_req, done, cond, flag_ia, flag_is, flag_de, top_ptr, tags,
                    m_done, m_cond, m_ia, m_is, m_de, m_top, m_tags);
            end
        end
    end

    task automatic do_cmp(input string req, input logic [1:0] o, input logic [63:0] a,
                          input logic [63:0] b, input logic msk,
                          input logic ui, input logic [2:0] ix);
        @(negedge clk);
        cur_req = req;
        op = o; top_val = a; src_val = b; inv_mask = msk; use_idx = ui; src_idx = ix;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
    endtask

    task automatic do_load(input string req, input logic [2:0] t, input logic [7:0] g);
        @(negedge clk);
        cur_req = req;
        ld_top = t; ld_tags = g; ld_en = 1'b1;
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    task automatic do_clear(input string req);
        @(negedge clk);
        cur_req = req;
        clr_flags = 1'b1;
        @(negedge clk);
        clr_flags = 1'b0;
    endtask

    localparam logic [63:0] ONE   = 64'h3FF0_0000_0000_0000;
    localparam logic [63:0] TWO   = 64'h4000_0000_0000_0000;
    localparam logic [63:0] MTWO  = 64'hC000_0000_0000_0000;
    localparam logic [63:0] PZERO = 64'h0;
    localparam logic [63:0] NZERO = 64'h8000_0000_0000_0000;
    localparam logic [63:0] PINF  = 64'h7FF0_0000_0000_0000;
    localparam logic [63:0] QNAN  = 64'h7FF8_0000_0000_0000;
    localparam logic [63:0] SNAN  = 64'h7FF0_0000_0000_0001;
    localparam logic [63:0] SUBN  = 64'h0000_0000_0000_0001;

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk_on = 1'b1;
        cur_req = "R13 reset";
        repeat (2) @(negedge clk);
        do_load("R13 load", 3'd0, 8'hFF);
        do_cmp("R1 R5 gt", 2'd0, TWO, ONE, 1'b1, 1'b0, 3'd0);
        do_cmp("R1 R5 lt", 2'd0, MTWO, ONE, 1'b1, 1'b0, 3'd0);
        do_cmp("R1 eq", 2'd0, TWO, TWO, 1'b1, 1'b0, 3'd0);
        do_cmp("R1 inf", 2'd0, PINF, TWO, 1'b1, 1'b0, 3'd0);
        do_cmp("R2 zero", 2'd0, NZERO, PZERO, 1'b1, 1'b0, 3'd0);
        do_cmp("R3 masked nan", 2'd0, QNAN, ONE, 1'b1, 1'b0, 3'd0);
        do_clear("R12 clear");
        do_cmp("R4 set lt", 2'd0, ONE, TWO, 1'b1, 1'b0, 3'd0);
        do_cmp("R4 unmasked nan", 2'd0, ONE, QNAN, 1'b0, 1'b0, 3'd0);
        do_clear("R12 clear");
        do_cmp("R6 quiet qnan", 2'd3, QNAN, ONE, 1'b0, 1'b0, 3'd0);
        do_cmp("R6 quiet snan", 2'd3, ONE, SNAN, 1'b1, 1'b0, 3'd0);
        do_clear("R12 clear");
        do_cmp("R9 denormal", 2'd0, SUBN, PZERO, 1'b1, 1'b0, 3'd0);
        do_cmp("R9 denormal neg", 2'd0, MTWO, SUBN, 1'b1, 1'b0, 3'd0);
        do_clear("R12 clear");
        do_load("R10 load", 3'd0, 8'b1111_1101);
        do_cmp("R10 default st1 empty", 2'd0, ONE, TWO, 1'b1, 1'b0, 3'd0);
        do_clear("R12 clear");
        do_cmp("R10 indexed st2", 2'd0, ONE, TWO, 1'b1, 1'b1, 3'd2);
        do_cmp("R8 unmasked underflow", 2'd0, TWO, ONE, 1'b0, 1'b1, 3'd1);
        do_clear("R12 clear");
        do_load("R7 load", 3'd6, 8'hFF);
        do_cmp("R7 pop once", 2'd1, TWO, ONE, 1'b1, 1'b0, 3'd0);
        do_cmp("R7 pop twice wrap", 2'd2, ONE, ONE, 1'b1, 1'b0, 3'd0);
        do_load("R8 load", 3'd3, 8'b0000_1000);
        do_cmp("R8 underflow with pops", 2'd2, ONE, TWO, 1'b1, 1'b0, 3'd0);
        do_load("R11 load", 3'd0, 8'hFF);
        @(negedge clk);
        cur_req = "R11 back to back";
        op = 2'd0; top_val = TWO; src_val = ONE; inv_mask = 1'b1; use_idx = 1'b0;
        start = 1'b1;
        @(negedge clk);
        top_val = ONE; src_val = TWO; op = 2'd1;
        @(negedge clk);
        start = 1'b0;
        repeat (2) @(negedge clk);
        @(negedge clk);
        cur_req = "R12 clear with new flag";
        clr_flags = 1'b1; top_val = QNAN; src_val = ONE; op = 2'd0; start = 1'b1;
        @(negedge clk);
        clr_flags = 1'b0; start = 1'b0;
        repeat (2) @(negedge clk);
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got running, exp finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule